// File: doc/BRIEF.md
# Chained Debug Trigger Match Unit

This block watches the address of each instruction fetch, each load and each store. It decides whether a hardware debug trigger asks for a trap on that access. It holds ten triggers in five fixed pairs. Every trigger compares one access class against a stored compare value. A chain link can join the two members of a pair so that the pair fires only when both members match in the same cycle. The two chained members may watch different access classes. For example, a fetch address and a store address can be required together.

Software-side logic writes the configuration of each trigger through two valid-qualified write ports. One port addresses the four fetch triggers and the other addresses the six memory triggers. The fields of one trigger are a compare mode, a data-select bit, a timing bit, an action bit, an arm (enable) bit, a chain bit and the compare value. For each access class, the block reports one cycle after the access whether a trap fires. It also reports the timing and action of the winning trigger, so that the trap logic can take the trap before the instruction or after it.

Top module: `dbgtrig_unit`

## Requirements
- R1: A synchronous reset clears every arm bit and every chain link, and drives all nine outputs to 0; once the reset is released, a trigger written with its arm bit set and with no new chain link works unchained.
- R2: Trigger t watches this class: triggers 0, 1, 6 and 8 watch fetch; 4, 5 and 9 watch load; 2, 3 and 7 watch store. Fetch write index 0..3 selects triggers 0, 1, 6, 8. Memory write index 0..5 selects triggers 2, 3, 4, 5, 7, 9. Memory index 6 or 7 writes nothing.
- R3: Compare mode 0 matches when the address equals the compare value. Mode 2 matches when the address is greater than or equal to it, unsigned. Mode 3 matches when the address is less than it, unsigned.
- R4: Compare mode 1 never matches.
- R5: A trigger whose data-select bit is 1 never matches, because data comparison is not provided.
- R6: A trigger with its arm bit at 0 never fires. An armed, unchained trigger fires whenever it matches a valid access of its class.
- R7: The chain link of pair p (triggers 2p and 2p+1) is taken from the chain field of a write to trigger 2p. A chained pair never fires through trigger 2p alone. It fires in the class of trigger 2p+1 only when both members match valid accesses in the same cycle.
- R8: A chained pair whose two timing bits differ never fires.
- R9: A chain request written to trigger 2 is ignored, so triggers 2 and 3 always act unchained.
- R10: Each class output reflects the access presented in the previous cycle. Without a valid access of its class, the fire output of that class is 0.
- R11: A class fires when any of its triggers fires. Its timing and action outputs come from the lowest-numbered firing trigger; for a chained pair that is trigger 2p+1. Both are 0 when the class does not fire.
- R12: A configuration write takes effect from the next cycle; an access in the same cycle as the write is judged with the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_fetch_we | input | 1 | Write strobe for a fetch trigger |
| cfg_fetch_idx | input | 2 | Fetch trigger slot |
| cfg_mem_we | input | 1 | Write strobe for a memory trigger |
| cfg_mem_idx | input | 3 | Memory trigger slot |
| cfg_mode | input | 2 | Compare mode |
| cfg_data_sel | input | 1 | Data-select bit (1 never matches) |
| cfg_late | input | 1 | Timing bit: 0 trap before, 1 trap after |
| cfg_action | input | 1 | Action bit reported on a fire |
| cfg_arm | input | 1 | Enable bit |
| cfg_chain | input | 1 | Chain link (used on even triggers) |
| cfg_value | input | ADDR_W | Compare value |
| fetch_vld | input | 1 | Fetch access valid |
| fetch_addr | input | ADDR_W | Fetch address |
| load_vld | input | 1 | Load access valid |
| load_addr | input | ADDR_W | Load address |
| store_vld | input | 1 | Store access valid |
| store_addr | input | ADDR_W | Store address |
| fetch_fire | output | 1 | Fetch class trap request |
| fetch_late | output | 1 | Timing bit of the winning fetch fire |
| fetch_action | output | 1 | Action bit of the winning fetch fire |
| load_fire | output | 1 | Load class trap request |
| load_late | output | 1 | Timing bit of the winning load fire |
| load_action | output | 1 | Action bit of the winning load fire |
| store_fire | output | 1 | Store class trap request |
| store_late | output | 1 | Timing bit of the winning store fire |
| store_action | output | 1 | Action bit of the winning store fire |

## Verification
The bench targets mixed-class chains: a fetch-store pair that fires when only one side is valid would show up as a store fire with no matching fetch. It also covers a chained pair whose timing bits disagree, a chain request on the store-store pair, and the reserved compare mode and data-select bit. A design that honoured any of these would raise fires that the bench does not expect. Priority between two firing triggers of one class is checked through the timing and action outputs, which would expose a highest-index winner. A write made in the same cycle as an access would catch a design that forwards new settings too early. A long sweep of random configurations near the compare boundaries (value minus one, equal, plus one) then exercises equality and the unsigned ordering edges.

// File: rtl/dbgtrig_pkg.sv
package dbgtrig_pkg;

   localparam int unsigned NUM_PAIRS = 5;
   localparam int unsigned NUM_TRIG  = 2 * NUM_PAIRS;
   localparam int unsigned NUM_FETCH = 4;
   localparam int unsigned NUM_MEM   = NUM_TRIG - NUM_FETCH;
   localparam int unsigned FIDX_W    = $clog2(NUM_FETCH);
   localparam int unsigned MIDX_W    = $clog2(NUM_MEM);
   localparam int unsigned NUM_CLS   = 3;

   typedef enum logic [1:0] {
      CLS_FETCH = 2'd0,
      CLS_LOAD  = 2'd1,
      CLS_STORE = 2'd2
   } acc_cls_e;

   typedef enum logic [1:0] {
      CMP_EQ   = 2'd0,
      CMP_RSVD = 2'd1,
      CMP_GE   = 2'd2,
      CMP_LT   = 2'd3
   } cmp_mode_e;

   typedef struct packed {
      cmp_mode_e mode;
      logic      data_sel;
      logic      late;
      logic      act;
      logic      arm;
   } trig_ctl_t;

   // class watched by each trigger; pairs are (F,F) (S,S) (L,L) (F,S) (F,L)
   function automatic acc_cls_e trig_cls(int t);
      case (t)
         0, 1, 6, 8: return CLS_FETCH;
         4, 5, 9:    return CLS_LOAD;
         default:    return CLS_STORE;
      endcase
   endfunction

   function automatic int fetch_slot_trig(int s);
      case (s)
         0:       return 0;
         1:       return 1;
         2:       return 6;
         default: return 8;
      endcase
   endfunction

   function automatic int mem_slot_trig(int s);
      case (s)
         0:       return 2;
         1:       return 3;
         2:       return 4;
         3:       return 5;
         4:       return 7;
         default: return 9;
      endcase
   endfunction

   // the store-store pair may not be linked
   function automatic bit pair_chainable(int p);
      return p != 1;
   endfunction

endpackage

// File: rtl/dbgtrig_cfg_bank.sv
module dbgtrig_cfg_bank
   import dbgtrig_pkg::*;
#(
   parameter int unsigned VAL_W = 64
) (
   input  logic                                clk,
   input  logic                                rst,
   input  logic                                f_we,
   input  logic [FIDX_W-1:0]                   f_idx,
   input  logic                                m_we,
   input  logic [MIDX_W-1:0]                   m_idx,
   input  trig_ctl_t                           wr_ctl,
   input  logic                                wr_chain,
   input  logic [VAL_W-1:0]                    wr_val,
   output trig_ctl_t [NUM_TRIG-1:0]            ctl_q,
   output logic [NUM_TRIG-1:0][VAL_W-1:0]      val_q,
   output logic [NUM_PAIRS-1:0]                chain_q
);

   logic [NUM_TRIG-1:0] wsel;
   logic [NUM_TRIG-1:0] arm_vec;

   // slot decode: memory slots past NUM_MEM select nothing
   always_comb begin
      wsel = '0;
      for (int s = 0; s < NUM_FETCH; s++) begin
         if (f_we && (f_idx == FIDX_W'(s)))
            wsel[fetch_slot_trig(s)] = 1'b1;
      end
      for (int s = 0; s < NUM_MEM; s++) begin
         if (m_we && (m_idx == MIDX_W'(s)))
            wsel[mem_slot_trig(s)] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ctl_q <= '0;
         val_q <= '0;
      end else begin
         for (int t = 0; t < NUM_TRIG; t++) begin
            if (wsel[t]) begin
               ctl_q[t] <= wr_ctl;
               val_q[t] <= wr_val;
            end
         end
      end
   end

   // chain link lives with the even member of each pair
   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '0;
      end else begin
         for (int p = 0; p < NUM_PAIRS; p++) begin
            if (pair_chainable(p) && wsel[2*p])
               chain_q[p] <= wr_chain;
         end
      end
   end

   always_comb begin
      for (int t = 0; t < NUM_TRIG; t++) arm_vec[t] = ctl_q[t].arm;
   end

   a_r1_cleared_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (arm_vec == '0 && chain_q == '0));

endmodule

// File: rtl/dbgtrig_cmp.sv
module dbgtrig_cmp
   import dbgtrig_pkg::*;
#(
   parameter int unsigned VAL_W = 64
) (
   input  logic             clk,
   input  logic             rst,
   input  trig_ctl_t        ctl,
   input  logic [VAL_W-1:0] val,
   input  logic [VAL_W-1:0] addr,
   input  logic             vld,
   output logic             hit
);

   logic rel;

   always_comb begin
      case (ctl.mode)
         CMP_EQ:  rel = (addr == val);
         CMP_GE:  rel = (addr >= val);
         CMP_LT:  rel = (addr <  val);
         default: rel = 1'b0;
      endcase
   end

   assign hit = vld && ctl.arm && !ctl.data_sel && rel;

   a_r4_reserved_mode_silent: assert property (@(posedge clk) disable iff (rst)
      (ctl.mode == CMP_RSVD) |-> !hit);

   a_r5_data_select_silent: assert property (@(posedge clk) disable iff (rst)
      ctl.data_sel |-> !hit);

   a_r6_disarmed_silent: assert property (@(posedge clk) disable iff (rst)
      !ctl.arm |-> !hit);

endmodule

// File: rtl/dbgtrig_pair.sv
module dbgtrig_pair (
   input  logic clk,
   input  logic rst,
   input  logic hit_lo,
   input  logic hit_hi,
   input  logic late_lo,
   input  logic late_hi,
   input  logic chain,
   output logic fire_lo,
   output logic fire_hi
);

   assign fire_lo = hit_lo && !chain;
   assign fire_hi = chain ? (hit_lo && hit_hi && (late_lo == late_hi)) : hit_hi;

   a_r7_chain_masks_low: assert property (@(posedge clk) disable iff (rst)
      chain |-> !fire_lo);

   a_r7_chain_needs_both: assert property (@(posedge clk) disable iff (rst)
      (chain && fire_hi) |-> (hit_lo && hit_hi));

   a_r8_chain_timing_agrees: assert property (@(posedge clk) disable iff (rst)
      (chain && fire_hi) |-> (late_lo == late_hi));

endmodule

// File: rtl/dbgtrig_unit.sv
module dbgtrig_unit
   import dbgtrig_pkg::*;
#(
   parameter int unsigned ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_fetch_we,
   input  logic [1:0]        cfg_fetch_idx,
   input  logic              cfg_mem_we,
   input  logic [2:0]        cfg_mem_idx,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_data_sel,
   input  logic              cfg_late,
   input  logic              cfg_action,
   input  logic              cfg_arm,
   input  logic              cfg_chain,
   input  logic [ADDR_W-1:0] cfg_value,
   input  logic              fetch_vld,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              load_vld,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              store_vld,
   input  logic [ADDR_W-1:0] store_addr,
   output logic              fetch_fire,
   output logic              fetch_late,
   output logic              fetch_action,
   output logic              load_fire,
   output logic              load_late,
   output logic              load_action,
   output logic              store_fire,
   output logic              store_late,
   output logic              store_action
);

   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_width
      $error("dbgtrig_unit: ADDR_W must lie in 8..64");
   end
   if (FIDX_W != 2 || MIDX_W != 3) begin : g_bad_index
      $error("dbgtrig_unit: slot index widths do not fit the ports");
   end

   trig_ctl_t                          wr_ctl;
   trig_ctl_t [NUM_TRIG-1:0]           ctl_q;
   logic [NUM_TRIG-1:0][ADDR_W-1:0]    val_q;
   logic [NUM_PAIRS-1:0]               chain_q;
   logic [NUM_CLS-1:0]                 cls_vld;
   logic [NUM_CLS-1:0][ADDR_W-1:0]     cls_addr;
   logic [NUM_TRIG-1:0]                hit;
   logic [NUM_TRIG-1:0]                fire;
   logic [NUM_CLS-1:0]                 any_d, late_d, act_d;
   logic [NUM_CLS-1:0]                 any_q, late_q, act_q;

   assign wr_ctl = '{mode: cmp_mode_e'(cfg_mode), data_sel: cfg_data_sel,
                     late: cfg_late, act: cfg_action, arm: cfg_arm};

   dbgtrig_cfg_bank #(.VAL_W(ADDR_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .f_we     (cfg_fetch_we),
      .f_idx    (cfg_fetch_idx),
      .m_we     (cfg_mem_we),
      .m_idx    (cfg_mem_idx),
      .wr_ctl   (wr_ctl),
      .wr_chain (cfg_chain),
      .wr_val   (cfg_value),
      .ctl_q    (ctl_q),
      .val_q    (val_q),
      .chain_q  (chain_q)
   );

   assign cls_vld[CLS_FETCH]  = fetch_vld;
   assign cls_vld[CLS_LOAD]   = load_vld;
   assign cls_vld[CLS_STORE]  = store_vld;
   assign cls_addr[CLS_FETCH] = fetch_addr;
   assign cls_addr[CLS_LOAD]  = load_addr;
   assign cls_addr[CLS_STORE] = store_addr;

   for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
      localparam int C = int'(trig_cls(t));
      dbgtrig_cmp #(.VAL_W(ADDR_W)) u_cmp (
         .clk  (clk),
         .rst  (rst),
         .ctl  (ctl_q[t]),
         .val  (val_q[t]),
         .addr (cls_addr[C]),
         .vld  (cls_vld[C]),
         .hit  (hit[t])
      );
   end

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      dbgtrig_pair u_pair (
         .clk     (clk),
         .rst     (rst),
         .hit_lo  (hit[2*p]),
         .hit_hi  (hit[2*p+1]),
         .late_lo (ctl_q[2*p].late),
         .late_hi (ctl_q[2*p+1].late),
         .chain   (chain_q[p]),
         .fire_lo (fire[2*p]),
         .fire_hi (fire[2*p+1])
      );
   end

   // walk from the top so the lowest-numbered firing trigger is written last
   always_comb begin
      any_d  = '0;
      late_d = '0;
      act_d  = '0;
      for (int t = NUM_TRIG - 1; t >= 0; t--) begin
         if (fire[t]) begin
            any_d[trig_cls(t)]  = 1'b1;
            late_d[trig_cls(t)] = ctl_q[t].late;
            act_d[trig_cls(t)]  = ctl_q[t].act;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         any_q  <= '0;
         late_q <= '0;
         act_q  <= '0;
      end else begin
         any_q  <= any_d;
         late_q <= late_d;
         act_q  <= act_d;
      end
   end

   assign fetch_fire   = any_q[CLS_FETCH];
   assign fetch_late   = late_q[CLS_FETCH];
   assign fetch_action = act_q[CLS_FETCH];
   assign load_fire    = any_q[CLS_LOAD];
   assign load_late    = late_q[CLS_LOAD];
   assign load_action  = act_q[CLS_LOAD];
   assign store_fire   = any_q[CLS_STORE];
   assign store_late   = late_q[CLS_STORE];
   assign store_action = act_q[CLS_STORE];

   a_r10_fetch_needs_access: assert property (@(posedge clk) disable iff (rst)
      !$past(fetch_vld) |-> !fetch_fire);
   a_r10_load_needs_access: assert property (@(posedge clk) disable iff (rst)
      !$past(load_vld) |-> !load_fire);
   a_r10_store_needs_access: assert property (@(posedge clk) disable iff (rst)
      !$past(store_vld) |-> !store_fire);
   a_r11_quiet_fields_zero: assert property (@(posedge clk) disable iff (rst)
      !fetch_fire |-> (!fetch_late && !fetch_action));

endmodule

// File: tb/dbgtrig_unit_tb.sv
module dbgtrig_unit_tb_top;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cfg_fetch_we = 0, cfg_mem_we = 0;
   logic [1:0] cfg_fetch_idx = 0;
   logic [2:0] cfg_mem_idx = 0;
   logic [1:0] cfg_mode = 0;
   logic cfg_data_sel = 0, cfg_late = 0, cfg_action = 0, cfg_arm = 0, cfg_chain = 0;
   logic [63:0] cfg_value = 0;
   logic fetch_vld = 0, load_vld = 0, store_vld = 0;
   logic [63:0] fetch_addr = 0, load_addr = 0, store_addr = 0;
   logic fetch_fire, fetch_late, fetch_action;
   logic load_fire, load_late, load_action;
   logic store_fire, store_late, store_action;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbgtrig_unit #(.ADDR_W(64)) dut_i (
      .clk(clk), .rst(rst),
      .cfg_fetch_we(cfg_fetch_we), .cfg_fetch_idx(cfg_fetch_idx),
      .cfg_mem_we(cfg_mem_we), .cfg_mem_idx(cfg_mem_idx),
      .cfg_mode(cfg_mode), .cfg_data_sel(cfg_data_sel), .cfg_late(cfg_late),
      .cfg_action(cfg_action), .cfg_arm(cfg_arm), .cfg_chain(cfg_chain),
      .cfg_value(cfg_value),
      .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
      .load_vld(load_vld), .load_addr(load_addr),
      .store_vld(store_vld), .store_addr(store_addr),
      .fetch_fire(fetch_fire), .fetch_late(fetch_late), .fetch_action(fetch_action),
      .load_fire(load_fire), .load_late(load_late), .load_action(load_action),
      .store_fire(store_fire), .store_late(store_late), .store_action(store_action)
   );

   // bench-side model of the configuration
   int          m_mode [10];
   bit          m_sel [10], m_late [10], m_act [10], m_arm [10];
   logic [63:0] m_val [10];
   bit          m_chain [5];
   bit          e_fire [3], e_late [3], e_act [3];

   function automatic int tb_cls(int t); // 0 fetch, 1 load, 2 store
      if (t == 0 || t == 1 || t == 6 || t == 8) return 0;
      if (t == 4 || t == 5 || t == 9) return 1;
      return 2;
   endfunction

   task automatic model_clear();
      for (int t = 0; t < 10; t++) begin
         m_mode[t] = 0; m_sel[t] = 0; m_late[t] = 0; m_act[t] = 0; m_arm[t] = 0; m_val[t] = 0;
      end
      for (int p = 0; p < 5; p++) m_chain[p] = 0;
   endtask

   function automatic bit ref_hit(int t, bit v, logic [63:0] a);
      if (!v || !m_arm[t] || m_sel[t]) return 0;
      case (m_mode[t])
         0: return a == m_val[t];
         2: return a >= m_val[t];
         3: return a <  m_val[t];
         default: return 0;
      endcase
   endfunction

   task automatic predict(bit fv, logic [63:0] fa, bit lv, logic [63:0] la, bit sv, logic [63:0] sa);
      bit h [10];
      bit f [10];
      for (int t = 0; t < 10; t++) begin
         int c = tb_cls(t);
         h[t] = ref_hit(t, c == 0 ? fv : (c == 1 ? lv : sv), c == 0 ? fa : (c == 1 ? la : sa));
      end
      for (int p = 0; p < 5; p++) begin
         if (m_chain[p]) begin
            f[2*p] = 0;
            f[2*p+1] = h[2*p] && h[2*p+1] && (m_late[2*p] == m_late[2*p+1]);
         end else begin
            f[2*p] = h[2*p];
            f[2*p+1] = h[2*p+1];
         end
      end
      for (int c = 0; c < 3; c++) begin e_fire[c] = 0; e_late[c] = 0; e_act[c] = 0; end
      for (int t = 9; t >= 0; t--) begin
         if (f[t]) begin
            e_fire[tb_cls(t)] = 1; e_late[tb_cls(t)] = m_late[t]; e_act[tb_cls(t)] = m_act[t];
         end
      end
   endtask

   task automatic chk(string req, string what, bit act, bit exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic compare_all(string req);
      chk(req, "fetch_fire", fetch_fire, e_fire[0]);
      chk(req, "fetch_late", fetch_late, e_late[0]);
      chk(req, "fetch_action", fetch_action, e_act[0]);
      chk(req, "load_fire", load_fire, e_fire[1]);
      chk(req, "load_late", load_late, e_late[1]);
      chk(req, "load_action", load_action, e_act[1]);
      chk(req, "store_fire", store_fire, e_fire[2]);
      chk(req, "store_late", store_late, e_late[2]);
      chk(req, "store_action", store_action, e_act[2]);
   endtask

   // starts and ends at a falling edge
   task automatic access(string req, bit fv, logic [63:0] fa, bit lv, logic [63:0] la,
                         bit sv, logic [63:0] sa);
      fetch_vld = fv; fetch_addr = fa; load_vld = lv; load_addr = la;
      store_vld = sv; store_addr = sa;
      predict(fv, fa, lv, la, sv, sa);
      @(posedge clk); @(negedge clk);
      fetch_vld = 0; load_vld = 0; store_vld = 0;
      compare_all(req);
   endtask

   task automatic drive_cfg(int t, int mode, bit sel, bit late, bit act, bit arm, bit chain,
                            logic [63:0] val);
      int fs, ms;
      fs = (t == 0) ? 0 : (t == 1) ? 1 : (t == 6) ? 2 : (t == 8) ? 3 : -1;
      ms = (t == 2) ? 0 : (t == 3) ? 1 : (t == 4) ? 2 : (t == 5) ? 3 : (t == 7) ? 4 : 5;
      cfg_mode = mode[1:0]; cfg_data_sel = sel; cfg_late = late; cfg_action = act;
      cfg_arm = arm; cfg_chain = chain; cfg_value = val;
      if (fs >= 0) begin cfg_fetch_we = 1; cfg_fetch_idx = fs[1:0]; end
      else begin cfg_mem_we = 1; cfg_mem_idx = ms[2:0]; end
   endtask

   task automatic model_write(int t, int mode, bit sel, bit late, bit act, bit arm, bit chain,
                              logic [63:0] val);
      m_mode[t] = mode; m_sel[t] = sel; m_late[t] = late; m_act[t] = act; m_arm[t] = arm;
      m_val[t] = val;
      if (t % 2 == 0 && t != 2) m_chain[t/2] = chain;
   endtask

   task automatic wr(int t, int mode, bit sel, bit late, bit act, bit arm, bit chain,
                     logic [63:0] val);
      drive_cfg(t, mode, sel, late, act, arm, chain, val);
      @(posedge clk); @(negedge clk);
      cfg_fetch_we = 0; cfg_mem_we = 0;
      model_write(t, mode, sel, late, act, arm, chain, val);
   endtask

   task automatic do_reset();
      rst = 1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 0;
      model_clear();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   logic [63:0] pool [4];

   initial begin
      model_clear();
      pool[0] = 64'h100; pool[1] = 64'h200; pool[2] = 64'h8000_0000_0000_0000;
      pool[3] = 64'hFFFF_FFFF_FFFF_FFF0;
      @(negedge clk);
      do_reset();
      // R1: reset state of outputs and of arm bits
      for (int c = 0; c < 3; c++) begin e_fire[c] = 0; e_late[c] = 0; e_act[c] = 0; end
      compare_all("R1");
      access("R1", 1, 64'h0, 1, 64'h0, 1, 64'h0);

      // R3 equality / R2 fetch slot mapping
      wr(0, 0, 0, 0, 1, 1, 0, 64'h100);
      access("R3", 1, 64'h100, 0, 0, 0, 0);
      access("R3", 1, 64'h101, 0, 0, 0, 0);
      access("R10", 0, 64'h100, 0, 0, 0, 0);
      // R3 unsigned ordering on load and store triggers
      wr(4, 2, 0, 0, 1, 1, 0, 64'h200);
      access("R3", 0, 0, 1, 64'h200, 0, 0);
      access("R3", 0, 0, 1, 64'h1FF, 0, 0);
      access("R3", 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
      wr(7, 3, 0, 1, 0, 1, 0, 64'h300);
      access("R3", 0, 0, 0, 0, 1, 64'h2FF);
      access("R3", 0, 0, 0, 0, 1, 64'h300);
      // R4 reserved mode, R5 data select, R6 disarmed
      wr(2, 1, 0, 0, 1, 1, 0, 64'h0);
      access("R4", 0, 0, 0, 0, 1, 64'h0);
      wr(3, 0, 1, 0, 1, 1, 0, 64'h50);
      access("R5", 0, 0, 0, 0, 1, 64'h50);
      wr(5, 0, 0, 0, 1, 0, 0, 64'h60);
      access("R6", 0, 0, 1, 64'h60, 0, 0);

      // R11 priority: triggers 0 and 1 both fire, lowest index wins
      wr(1, 0, 0, 1, 0, 1, 0, 64'h100);
      access("R11", 1, 64'h100, 0, 0, 0, 0);
      chk("R11", "fetch_late literal", fetch_late, 1'b0);
      chk("R11", "fetch_action literal", fetch_action, 1'b1);

      // R7 chained pair 0, both members fetch
      wr(0, 0, 0, 0, 1, 1, 1, 64'h100);
      wr(1, 2, 0, 0, 0, 1, 0, 64'h80);
      access("R7", 1, 64'h100, 0, 0, 0, 0);
      chk("R7", "fetch_fire literal", fetch_fire, 1'b1);
      access("R7", 1, 64'h90, 0, 0, 0, 0);
      // R8 differing timing kills the pair
      wr(1, 2, 0, 1, 0, 1, 0, 64'h80);
      access("R8", 1, 64'h100, 0, 0, 0, 0);
      chk("R8", "fetch_fire literal", fetch_fire, 1'b0);

      // R7 mixed pair 3: fetch member with store member
      wr(6, 0, 0, 1, 0, 1, 1, 64'h400);
      wr(7, 0, 0, 1, 1, 1, 0, 64'h500);
      access("R7", 1, 64'h400, 0, 0, 1, 64'h500);
      chk("R7", "store_fire literal", store_fire, 1'b1);
      chk("R7", "fetch_fire literal", fetch_fire, 1'b0);
      access("R7", 1, 64'h400, 0, 0, 0, 64'h500);
      access("R7", 0, 64'h400, 0, 0, 1, 64'h500);

      // R9 chain request on the store-store pair is ignored
      wr(2, 0, 0, 0, 1, 1, 1, 64'h700);
      wr(3, 0, 0, 0, 0, 1, 0, 64'h800);
      access("R9", 0, 0, 0, 0, 1, 64'h700);
      chk("R9", "store_fire literal", store_fire, 1'b1);

      // R12 write and access in the same cycle
      wr(4, 0, 0, 0, 0, 0, 0, 64'h0);
      drive_cfg(9, 0, 0, 0, 1, 1, 0, 64'h900);
      load_vld = 1; load_addr = 64'h900;
      @(posedge clk); @(negedge clk);
      cfg_fetch_we = 0; cfg_mem_we = 0; load_vld = 0;
      model_write(9, 0, 0, 0, 1, 1, 0, 64'h900);
      chk("R12", "load_fire same cycle", load_fire, 1'b0);
      access("R12", 0, 0, 1, 64'h900, 0, 0);
      chk("R12", "load_fire next cycle", load_fire, 1'b1);

      // R1 chain links cleared by reset
      do_reset();
      wr(1, 0, 0, 0, 0, 1, 0, 64'h100);
      access("R1", 1, 64'h100, 0, 0, 0, 0);
      chk("R1", "fetch_fire unchained after reset", fetch_fire, 1'b1);

      // R2 memory index 6 and 7 write nothing
      do_reset();
      cfg_mem_we = 1; cfg_mem_idx = 3'd6; cfg_mode = 0; cfg_arm = 1; cfg_value = 64'hA0;
      @(posedge clk); @(negedge clk);
      cfg_mem_idx = 3'd7;
      @(posedge clk); @(negedge clk);
      cfg_mem_we = 0;
      access("R2", 1, 64'hA0, 1, 64'hA0, 1, 64'hA0);

      // sweep: random settings near compare boundaries
      for (int it = 0; it < 3000; it++) begin
         int t = int'($urandom % 10);
         int md = int'($urandom % 4);
         wr(t, md, ($urandom % 8) == 0, $urandom % 2 == 1, $urandom % 2 == 1,
            ($urandom % 4) != 0, $urandom % 2 == 1, pool[$urandom % 4]);
         for (int k = 0; k < 2; k++) begin
            access("R2/R3/R6/R7/R8/R11",
                   $urandom % 4 != 0, pool[$urandom % 4] + 64'($urandom % 3) - 64'd1,
                   $urandom % 4 != 0, pool[$urandom % 4] + 64'($urandom % 3) - 64'd1,
                   $urandom % 4 != 0, pool[$urandom % 4] + 64'($urandom % 3) - 64'd1);
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule